// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of an eight-input, ten-bit successive-approximation converter. It selects the analog input through `mux_sel` and holds `sample_en` high while that input is sampled. It then drives a trial code on `dac_code` and reads back the single-bit comparator answer on `adc_cmp`. The bits are resolved from the most significant bit down to the least, one bit per clock-enable tick. A programmable divider sets how often a tick occurs.

Software controls the block through a simple valid/address/data register port. It can start one conversion, or it can enable burst scanning, in which the channels selected by a mask are converted again and again in ascending order. A conversion can also be started by a synchronized edge on an external pin or on a timer-match line, and the edge is selectable. Every channel has its own result register, which holds the value, a done flag and an overrun flag. The interrupt line is the OR of the done flags of the channels enabled for interrupt. A power-down bit stops all activity.

Top module: `adc_seq_top`

## Requirements
- R1: A conversion samples the input first and then makes 10 trials, MSB first. The first trial code is 0x200. Each later trial code is the bits kept so far plus the bit under test. A bit is kept when `adc_cmp` is 1, which means the input is at or above the trial code. The stored result is the final code.
- R2: A divider value d in control bits [15:8] gives one tick every d+1 clocks. Sampling lasts until the next tick. The done flag and the interrupt appear exactly 10(d+1)+1 clocks after `sample_en` falls.
- R3: The result of channel k goes to address 8+k, with the value in bits [9:0], overrun in bit 30 and done in bit 31. Only register k is written, and its done flag is set. A bus read returns the old content and clears both flags.
- R4: Overrun is set when a new result is written while done is still set. A read in the same cycle as the write keeps the new value with done=1 and overrun=0.
- R5: Burst mode (control bit 16) converts the masked channels (control bits [7:0]) without stopping. Channels are taken in ascending order and the scan wraps after channel 7. Channels whose mask bit is clear are skipped. `mux_sel` stays constant during a conversion.
- R6: A burst with one masked channel converts that channel over and over. When done is polled every cycle, every result is seen and overrun never sets.
- R7: The hardware start source is set by control bits [19:18] (0 none, 1 pin, 2 timer). Control bit 20 chooses the edge (0 rising, 1 falling). The trigger is synchronized, and the selected edge starts one conversion of the lowest masked channel. Edges from a source that is not selected, and edges of the other polarity, have no effect.
- R8: Writing 1 to bit 0 at address 1 starts one conversion of the lowest-index masked channel. With an empty mask nothing starts.
- R9: Power-down (control bit 17) blocks every start and aborts a running conversion without writing a result. While it is set, `sample_en` is 0 and `dac_code` is 0.
- R10: `irq` is high exactly when some channel k has done set and bit k of the enable register (address 2, bits [7:0]) set.
- R11: The control register at address 0 reads back bits [20:0] as written. The control register and the enable register both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 21 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| trig_pin | input | 1 | External pin trigger, asynchronous |
| trig_timer | input | 1 | Timer-match trigger, asynchronous |
| adc_cmp | input | 1 | Comparator: 1 = input at or above trial code |
| mux_sel | output | 3 | Analog multiplexer select |
| dac_code | output | 10 | Trial code for the DAC |
| sample_en | output | 1 | Sampling phase active |
| irq | output | 1 | Interrupt |

## Verification
Two events can fall in the same clock on a result register: a bus read that clears the flags, and the write of a new conversion result. The bench provokes this by running a burst on a single channel while it holds a read of that channel's register every cycle, so every result write lands on a read. The collision is judged correct when each conversion still shows up as done with the right value, enough results appear in the window, and overrun never rises. A second run lets two results land with no read between them to show the opposite case, where overrun is set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int REG_CTRL  = 0;
   localparam int REG_START = 1;
   localparam int REG_IRQEN = 2;
   localparam int RES_BASE  = 8;

   typedef enum logic [1:0] {
      TRG_NONE  = 2'd0,
      TRG_PIN   = 2'd1,
      TRG_TIMER = 2'd2,
      TRG_RSVD  = 2'd3
   } trg_src_e;

   typedef enum logic [1:0] {
      SAR_IDLE   = 2'd0,
      SAR_SAMPLE = 2'd1,
      SAR_TRIAL  = 2'd2
   } sar_state_e;
endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   // >= keeps the count bounded when the divider shrinks mid-count
   assign tick = !hold && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fall_sel,
   output logic edge_p
);
   logic [SYNC-1:0] stg;
   logic            prev_q;

   for (genvar s = 0; s < SYNC; s++) begin : g_stg
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= 1'b0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= stg[SYNC-1];
   end

   assign edge_p = fall_sel ? (prev_q && !stg[SYNC-1]) : (!prev_q && stg[SYNC-1]);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
   import adc_seq_pkg::*;
#(
   parameter int RES = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           abort,
   input  logic           start,
   input  logic           tick,
   input  logic           cmp,
   output logic           busy,
   output logic           sampling,
   output logic [RES-1:0] trial,
   output logic           done_p,
   output logic [RES-1:0] result
);
   localparam int BI_W = $clog2(RES);

   sar_state_e     st_q;
   logic [RES-1:0] acc_q;
   logic [BI_W-1:0] bi_q;
   logic [RES-1:0] bit_oh;

   assign bit_oh   = RES'(1) << bi_q;
   assign busy     = (st_q != SAR_IDLE);
   assign sampling = (st_q == SAR_SAMPLE);
   assign trial    = (st_q == SAR_TRIAL) ? (acc_q | bit_oh) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SAR_IDLE;
         acc_q  <= '0;
         bi_q   <= '0;
         done_p <= 1'b0;
         result <= '0;
      end else begin
         done_p <= 1'b0;
         if (abort) begin
            st_q <= SAR_IDLE;
         end else begin
            case (st_q)
               SAR_IDLE: if (start) begin
                  st_q  <= SAR_SAMPLE;
                  acc_q <= '0;
               end
               SAR_SAMPLE: if (tick) begin
                  st_q <= SAR_TRIAL;
                  bi_q <= BI_W'(RES - 1);
               end
               SAR_TRIAL: if (tick) begin
                  acc_q <= acc_q | (cmp ? bit_oh : '0);
                  if (bi_q == '0) begin
                     st_q   <= SAR_IDLE;
                     done_p <= 1'b1;
                     result <= acc_q | (cmp ? bit_oh : '0);
                  end else begin
                     bi_q <= bi_q - 1'b1;
                  end
               end
               default: st_q <= SAR_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
   import adc_seq_pkg::*;
#(
   parameter  int NCH    = 8,
   parameter  int RES    = 10,
   parameter  int DIV_W  = 8,
   parameter  int ADDR_W = 4,
   parameter  int SYNC   = 2,
   localparam int WD_W   = 21,
   localparam int RD_W   = 32,
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WD_W-1:0]   bus_wdata,
   output logic [RD_W-1:0]   bus_rdata,
   input  logic              trig_pin,
   input  logic              trig_timer,
   input  logic              adc_cmp,
   output logic [CH_W-1:0]   mux_sel,
   output logic [RES-1:0]    dac_code,
   output logic              sample_en,
   output logic              irq
);
   // elaboration-time parameter checks
   if (NCH < 2 || NCH > 8)             begin : g_bad_nch  $error("NCH out of range");   end
   if (DIV_W < 1 || DIV_W > 8)         begin : g_bad_div  $error("DIV_W out of range"); end
   if (RES < 2 || RES > 16)            begin : g_bad_res  $error("RES out of range");   end
   if (SYNC < 2)                       begin : g_bad_sync $error("SYNC below 2");       end
   if ((1 << ADDR_W) < RES_BASE + NCH) begin : g_bad_addr $error("ADDR_W too small");   end

   logic [NCH-1:0]   mask_q, irq_en_q;
   logic [DIV_W-1:0] div_q;
   logic             burst_q, pdown_q, fall_q;
   trg_src_e         src_q;
   logic [CH_W-1:0]  conv_ch_q;

   logic wr, rd, sw_start, tick, pin_edge, tmr_edge, hw_edge, start_req;
   logic core_busy, conv_done;
   logic [RES-1:0]     conv_res;
   logic [NCH-1:0]     done_vec, ovr_vec;
   logic [NCH*RES-1:0] res_flat;

   function automatic logic [CH_W-1:0] next_chan(input logic [NCH-1:0] m,
                                                input logic [CH_W-1:0] cur);
      int idx;
      next_chan = cur;
      for (int i = NCH; i >= 1; i--) begin
         idx = (int'(cur) + i) % NCH;
         if (m[idx]) next_chan = CH_W'(idx);
      end
   endfunction

   assign wr       = bus_valid && bus_write;
   assign rd       = bus_valid && !bus_write;
   assign sw_start = wr && (bus_addr == ADDR_W'(REG_START)) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         div_q    <= '0;
         burst_q  <= 1'b0;
         pdown_q  <= 1'b0;
         src_q    <= TRG_NONE;
         fall_q   <= 1'b0;
         irq_en_q <= '0;
      end else if (wr) begin
         if (bus_addr == ADDR_W'(REG_CTRL)) begin
            mask_q  <= bus_wdata[NCH-1:0];
            div_q   <= bus_wdata[8 +: DIV_W];
            burst_q <= bus_wdata[16];
            pdown_q <= bus_wdata[17];
            src_q   <= trg_src_e'(bus_wdata[19:18]);
            fall_q  <= bus_wdata[20];
         end
         if (bus_addr == ADDR_W'(REG_IRQEN))
            irq_en_q <= bus_wdata[NCH-1:0];
      end
   end

   adc_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .hold(pdown_q), .div(div_q), .tick(tick)
   );

   adc_trig_edge #(.SYNC(SYNC)) u_pin (
      .clk(clk), .rst_n(rst_n), .din(trig_pin), .fall_sel(fall_q), .edge_p(pin_edge)
   );

   adc_trig_edge #(.SYNC(SYNC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .din(trig_timer), .fall_sel(fall_q), .edge_p(tmr_edge)
   );

   assign hw_edge   = ((src_q == TRG_PIN) && pin_edge) || ((src_q == TRG_TIMER) && tmr_edge);
   assign start_req = !pdown_q && (|mask_q) && !core_busy && (burst_q || sw_start || hw_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         conv_ch_q <= CH_W'(NCH - 1);
      else if (start_req)
         conv_ch_q <= burst_q ? next_chan(mask_q, conv_ch_q)
                              : next_chan(mask_q, CH_W'(NCH - 1));
   end

   adc_sar_core #(.RES(RES)) u_sar (
      .clk(clk), .rst_n(rst_n), .abort(pdown_q), .start(start_req), .tick(tick),
      .cmp(adc_cmp), .busy(core_busy), .sampling(sample_en), .trial(dac_code),
      .done_p(conv_done), .result(conv_res)
   );

   assign mux_sel = conv_ch_q;

   for (genvar k = 0; k < NCH; k++) begin : g_res
      logic [RES-1:0] val_q;
      logic           done_q, ovr_q, wr_k, rd_k;

      assign wr_k = conv_done && (conv_ch_q == CH_W'(k));
      assign rd_k = rd && (bus_addr == ADDR_W'(RES_BASE + k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
         end else if (wr_k) begin
            val_q  <= conv_res;
            done_q <= 1'b1;
            ovr_q  <= done_q && !rd_k;
         end else if (rd_k) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
      end

      assign res_flat[k*RES +: RES] = val_q;
      assign done_vec[k]            = done_q;
      assign ovr_vec[k]             = ovr_q;
   end

   assign irq = |(done_vec & irq_en_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_CTRL)) begin
         bus_rdata[NCH-1:0]    = mask_q;
         bus_rdata[8 +: DIV_W] = div_q;
         bus_rdata[16]         = burst_q;
         bus_rdata[17]         = pdown_q;
         bus_rdata[19:18]      = src_q;
         bus_rdata[20]         = fall_q;
      end
      if (bus_addr == ADDR_W'(REG_IRQEN))
         bus_rdata[NCH-1:0] = irq_en_q;
      for (int k = 0; k < NCH; k++) begin
         if (bus_addr == ADDR_W'(RES_BASE + k)) begin
            bus_rdata[RES-1:0] = res_flat[k*RES +: RES];
            bus_rdata[30]      = ovr_vec[k];
            bus_rdata[31]      = done_vec[k];
         end
      end
   end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int NCH  = 8,
   parameter int RES  = 10,
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            sample_en,
   input logic [RES-1:0]  dac_code,
   input logic [CH_W-1:0] mux_sel,
   input logic [NCH-1:0]  mask,
   input logic            pdown,
   input logic [NCH-1:0]  done_vec,
   input logic [NCH-1:0]  ovr_vec,
   input logic            irq,
   input logic [NCH-1:0]  irq_en
);
   AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sample_en) && busy) |-> (dac_code == (RES'(1) << (RES - 1)))); // R1

   AST_START_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ((($past(mask) >> mux_sel) & NCH'(1)) != '0)); // R8

   AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mux_sel)); // R5

   AST_PDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pdown |=> (!busy && dac_code == '0)); // R9

   AST_OVR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovr_vec & ~$past(ovr_vec) & ~$past(done_vec)) == '0)); // R4

   AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en != '0)); // R10
endmodule

bind adc_seq_top adc_seq_chk #(.NCH(NCH), .RES(RES), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(core_busy), .sample_en(sample_en),
   .dac_code(dac_code), .mux_sel(mux_sel), .mask(mask_q), .pdown(pdown_q),
   .done_vec(done_vec), .ovr_vec(ovr_vec), .irq(irq), .irq_en(irq_en_q)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [20:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        trig_pin = 1'b0, trig_timer = 1'b0;
   logic        adc_cmp;
   logic [2:0]  mux_sel;
   logic [9:0]  dac_code;
   logic        sample_en, irq;

   logic [9:0]  vin [8];
   int          n_chk = 0, n_fail = 0;
   int          seq [40];
   int          seq_n = 0;
   bit          rec_on = 0, prev_se = 0;

   always #2 clk = ~clk;

   adc_seq_top dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .trig_pin(trig_pin), .trig_timer(trig_timer), .adc_cmp(adc_cmp),
      .mux_sel(mux_sel), .dac_code(dac_code), .sample_en(sample_en), .irq(irq)
   );

   // analog model: comparator high when input is at or above the trial code
   always_comb adc_cmp = (vin[mux_sel] >= dac_code);

   always @(negedge clk) begin
      if (rec_on && sample_en && !prev_se && seq_n < 40) begin
         seq[seq_n] = int'(mux_sel);
         seq_n++;
      end
      prev_se = sample_en;
   end

   function automatic int sar_model(input int v);
      int acc = 0;
      for (int b = 9; b >= 0; b--) if (v >= (acc | (1 << b))) acc = acc | (1 << b);
      return acc;
   endfunction

   function automatic int exp_next(input int m, input int cur);
      for (int i = 1; i <= 8; i++) if (m[(cur + i) % 8]) return (cur + i) % 8;
      return cur;
   endfunction

   function automatic int lowest(input int m);
      return exp_next(m, 7);
   endfunction

   function automatic logic [20:0] mk_ctrl(input int m, input int d, input bit b,
                                           input bit pd, input int src, input bit fall);
      return {fall, 2'(src), pd, b, 8'(d), 8'(m)};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int a, input logic [20:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = 4'(a);
      #1 d = bus_rdata;
      @(negedge clk);
      bus_valid = 0;
   endtask

   task automatic clear_all();
      logic [31:0] d;
      for (int k = 0; k < 8; k++) bus_rd(8 + k, d);
   endtask

   task automatic wait_done(input int ch, output logic [31:0] d);
      for (int i = 0; i < 2000; i++) begin
         bus_rd(8 + ch, d);
         if (d[31]) break;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int          m, ch, n, cnt, bad;
      void'($urandom(32'h5eed_0123));
      for (int k = 0; k < 8; k++) vin[k] = 10'(k * 97 + 13);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // reset state
      bus_rd(0, d);  chk(d == 0, "R11 ctrl reset", int'(d), 0);
      bus_rd(2, d);  chk(d == 0, "R11 irq enable reset", int'(d), 0);
      bus_rd(11, d); chk(d == 0, "R3 result reset", int'(d), 0);
      chk(!irq && dac_code == 0 && !sample_en, "R9 idle outputs at reset", int'(dac_code), 0);

      // R11 readback, powered down so nothing runs
      bus_wr(0, 21'h1E_5A3C); bus_rd(0, d);
      chk(d == 32'h1E_5A3C, "R11 ctrl readback", int'(d), 32'h1E_5A3C);
      bus_wr(2, 21'h00_00A5); bus_rd(2, d);
      chk(d == 32'hA5, "R11 irq enable readback", int'(d), 32'hA5);
      bus_wr(2, 0);
      bus_wr(0, 0);

      // R8 empty mask: nothing starts
      bus_wr(1, 1);
      n = 0;
      repeat (30) begin @(negedge clk); if (sample_en) n++; end
      chk(n == 0, "R8 empty mask no start", n, 0);

      // R1 / R8 directed corner values on the lowest masked channel
      vin[1] = 10'd0; vin[2] = 10'd1023; vin[3] = 10'd512; vin[4] = 10'd511; vin[5] = 10'd1;
      for (int c = 1; c <= 5; c++) begin
         bus_wr(0, mk_ctrl((1 << c) | 8'h80, 0, 0, 0, 0, 0));
         bus_wr(1, 1);
         wait_done(c, d);
         chk(d[31] && d[9:0] == 10'(sar_model(vin[c])), "R1 corner value",
             int'(d[9:0]), sar_model(vin[c]));
         bus_rd(15, d);
         chk(!d[31], "R8 only lowest masked channel converts", int'(d[31]), 0);
      end

      // R2 latency from end of sampling to done/irq
      foreach (vin[k]) vin[k] = 10'($urandom_range(0, 1023));
      bus_wr(2, 8'h08);
      for (int t = 0; t < 4; t++) begin
         int dv;
         dv = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 3 : 5;
         clear_all();
         bus_wr(0, mk_ctrl(8'h08, dv, 0, 0, 0, 0));
         bus_wr(1, 1);
         while (sample_en) @(negedge clk);
         n = 0;
         while (!irq && n < 500) begin @(negedge clk); n++; end
         chk(n == 10 * (dv + 1) + 1, "R2 trial phase length", n, 10 * (dv + 1) + 1);
         bus_rd(11, d);
         chk(d[9:0] == 10'(sar_model(vin[3])), "R1 value with divider", int'(d[9:0]),
             sar_model(vin[3]));
         chk(!irq, "R10 irq drops after read", int'(irq), 0);
      end

      // R4 overrun: two results without a read
      bus_wr(0, mk_ctrl(8'h08, 0, 0, 0, 0, 0));
      bus_wr(1, 1); repeat (60) @(negedge clk);
      bus_wr(1, 1); repeat (60) @(negedge clk);
      bus_rd(11, d);
      chk(d[31] && d[30], "R4 overrun set", int'(d[31:30]), 3);
      bus_rd(11, d);
      chk(!d[31] && !d[30], "R3 read clears flags", int'(d[31:30]), 0);

      // R10 enable gating
      bus_wr(2, 8'h00);
      bus_wr(1, 1); repeat (60) @(negedge clk);
      chk(!irq, "R10 irq masked", int'(irq), 0);
      bus_wr(2, 8'h10); @(negedge clk);
      chk(!irq, "R10 other channel enabled", int'(irq), 0);
      bus_wr(2, 8'h08); @(negedge clk);
      chk(irq, "R10 irq enabled", int'(irq), 1);
      bus_wr(2, 8'h00);
      clear_all();

      // R5 burst order over a sparse mask
      for (int pass = 0; pass < 2; pass++) begin
         m = (pass == 0) ? 8'hA5 : ($urandom_range(1, 255) | 8'h01);
         clear_all();
         seq_n = 0; rec_on = 1;
         bus_wr(0, mk_ctrl(m, 0, 1, 0, 0, 0));
         for (int i = 0; i < 3000 && seq_n < 12; i++) @(negedge clk);
         rec_on = 0;
         bus_wr(0, mk_ctrl(m, 0, 0, 0, 0, 0));
         repeat (60) @(negedge clk);
         bad = 0;
         for (int i = 1; i < seq_n; i++)
            if (seq[i] != exp_next(m, seq[i-1])) bad++;
         chk(seq_n >= 12 && bad == 0, "R5 ascending wrap order", bad, 0);
         for (int k = 0; k < 8; k++) begin
            bus_rd(8 + k, d);
            if (m[k]) chk(d[31] && d[9:0] == 10'(sar_model(vin[k])), "R5 masked result",
                          int'(d[9:0]), sar_model(vin[k]));
            else      chk(!d[31], "R5 skipped channel untouched", int'(d[31]), 0);
         end
      end

      // R6 single-channel burst polled every cycle (read/write collision)
      ch = 6;
      bus_wr(0, mk_ctrl(1 << ch, 0, 1, 0, 0, 0));
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = 4'(8 + ch);
      cnt = 0; bad = 0;
      repeat (260) begin
         #1 d = bus_rdata;
         if (d[31]) begin
            cnt++;
            if (d[30] || d[9:0] != 10'(sar_model(vin[ch]))) bad++;
         end
         @(negedge clk);
      end
      bus_valid = 0;
      chk(cnt >= 15, "R6 every result seen", cnt, 15);
      chk(bad == 0, "R6 no overrun or bad value", bad, 0);
      bus_wr(0, mk_ctrl(1 << ch, 0, 0, 0, 0, 0));
      repeat (60) @(negedge clk);
      clear_all();

      // R7 hardware starts
      bus_wr(0, mk_ctrl(8'h04, 0, 0, 0, 1, 0));
      @(negedge clk) trig_pin = 1; repeat (60) @(negedge clk);
      bus_rd(10, d); chk(d[31], "R7 pin rising start", int'(d[31]), 1);
      @(negedge clk) trig_pin = 0; repeat (60) @(negedge clk);
      bus_rd(10, d); chk(!d[31], "R7 pin falling ignored when rising selected", int'(d[31]), 0);
      bus_wr(0, mk_ctrl(8'h04, 0, 0, 0, 1, 1));
      @(negedge clk) trig_pin = 1; repeat (60) @(negedge clk);
      bus_rd(10, d); chk(!d[31], "R7 pin rising ignored when falling selected", int'(d[31]), 0);
      @(negedge clk) trig_pin = 0; repeat (60) @(negedge clk);
      bus_rd(10, d); chk(d[31], "R7 pin falling start", int'(d[31]), 1);
      bus_wr(0, mk_ctrl(8'h04, 0, 0, 0, 2, 0));
      @(negedge clk) trig_pin = 1;
      @(negedge clk) trig_pin = 0; repeat (60) @(negedge clk);
      bus_rd(10, d); chk(!d[31], "R7 pin ignored when timer selected", int'(d[31]), 0);
      @(negedge clk) trig_timer = 1;
      @(negedge clk) trig_timer = 0; repeat (60) @(negedge clk);
      bus_rd(10, d); chk(d[31], "R7 timer pulse start", int'(d[31]), 1);
      bus_wr(0, mk_ctrl(8'h04, 0, 0, 0, 0, 0));
      @(negedge clk) begin trig_timer = 1; trig_pin = 1; end
      @(negedge clk) begin trig_timer = 0; trig_pin = 0; end
      repeat (60) @(negedge clk);
      bus_rd(10, d); chk(!d[31], "R7 no source selected", int'(d[31]), 0);

      // R9 power-down blocks and aborts
      bus_wr(0, mk_ctrl(8'h02, 0, 0, 1, 0, 0));
      bus_wr(1, 1); repeat (60) @(negedge clk);
      bus_rd(9, d); chk(!d[31], "R9 start blocked", int'(d[31]), 0);
      bus_wr(0, mk_ctrl(8'h02, 7, 0, 0, 0, 0));
      bus_wr(1, 1); repeat (20) @(negedge clk);
      bus_wr(0, mk_ctrl(8'h02, 7, 0, 1, 0, 0));
      @(negedge clk);
      chk(!sample_en && dac_code == 0, "R9 outputs idle", int'(dac_code), 0);
      bus_wr(0, mk_ctrl(8'h02, 7, 0, 0, 0, 0));
      repeat (200) @(negedge clk);
      bus_rd(9, d); chk(!d[31], "R9 aborted conversion leaves no result", int'(d[31]), 0);

      // random single conversions
      for (int it = 0; it < 24; it++) begin
         int dv;
         foreach (vin[k]) vin[k] = 10'($urandom_range(0, 1023));
         m  = $urandom_range(1, 255);
         dv = $urandom_range(0, 3);
         ch = lowest(m);
         bus_wr(0, mk_ctrl(m, dv, 0, 0, 0, 0));
         bus_wr(1, 1);
         wait_done(ch, d);
         chk(d[31] && d[9:0] == 10'(sar_model(vin[ch])), "R1 random conversion",
             int'(d[9:0]), sar_model(vin[ch]));
         bus_rd(8 + ch, d);
         chk(!d[31], "R3 done cleared by read", int'(d[31]), 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule